// File: doc/BRIEF.md
# Reorder Buffer with Dataflow Issue

This block is a small circular window of in-flight instructions. Each slot holds a decoded instruction and serves two roles. It is an issue slot that gathers its operands. It is also a reorder-buffer entry that keeps the result until retirement. The decode stage writes a slot at the ring's tail. It supplies an opcode, a destination register number and two sources. Each source is given either as a known value or as the slot index (tag) of the producing instruction. The index of the written slot becomes the tag of the new instruction.

A result bus carries tag/value pairs back from the functional units. Every waiting source that matches the tag captures the value, and the producing slot stores the value as its result. Every cycle the oldest slot whose sources are both present, and which has not yet been sent, goes out on the issue port. Issue is therefore out of order. Retirement is in order. The slot at the ring's head leaves through the commit port, which feeds the architectural register file, once its result is present.

Top module: `rob_dataflow`

## Requirements
- R1: After reset the ring is empty: `alloc_stall` is 0, `alloc_tag` is 0, and neither `iss_valid` nor `cmt_valid` is asserted.
- R2: A request with `alloc_valid`=1 and `alloc_stall`=0 takes the slot shown on `alloc_tag`. Successive allocations receive consecutive tags.
- R3: A slot is offered on the issue port, with its opcode and both operand values, in the cycle after its last source becomes present. A younger ready slot issues ahead of an older waiting one. Each slot issues exactly once.
- R4: While all DEPTH slots are occupied, `alloc_stall` is 1 and a request is ignored: `alloc_tag` does not move and no slot is written.
- R5: When several slots are ready in the same cycle, the one nearest the commit pointer in ring order issues first.
- R6: A result bus beat (`res_valid`, `res_tag`, `res_data`) fills every waiting source whose tag field (low tag bits of the source field) equals `res_tag`. It also records the result in slot `res_tag`.
- R7: A source that is allocated as pending, while the result bus carries a matching tag in the same cycle, captures that value at allocation.
- R8: The head slot commits, with `cmt_dst` and its stored result on `cmt_data`, in the cycle after its result arrives. Commits happen at most one per cycle and strictly in allocation order, and each commit frees the slot.
- R9: The tag pointers wrap from DEPTH-1 to 0, so allocation continues around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests a slot this cycle |
| alloc_op | input | OP_W | Opcode of the new instruction |
| alloc_dst | input | AREG_W | Architectural destination register |
| alloc_s1_rdy | input | 1 | Source 1 is a known value (1) or a pending tag (0) |
| alloc_s1 | input | DATA_W | Source 1 value, or tag in the low TAG_W bits |
| alloc_s2_rdy | input | 1 | Source 2 is a known value (1) or a pending tag (0) |
| alloc_s2 | input | DATA_W | Source 2 value, or tag in the low TAG_W bits |
| alloc_stall | output | 1 | Ring full, request refused |
| alloc_tag | output | TAG_W | Tag given to the next allocation |
| res_valid | input | 1 | Result bus beat present |
| res_tag | input | TAG_W | Tag of the producing slot |
| res_data | input | DATA_W | Result value |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_op | output | OP_W | Opcode of the issued instruction |
| iss_a | output | DATA_W | Operand 1 value |
| iss_b | output | DATA_W | Operand 2 value |
| cmt_valid | output | 1 | Head slot retires this cycle |
| cmt_dst | output | AREG_W | Register to write |
| cmt_data | output | DATA_W | Value to write |

## Verification
The bench builds the block with its defaults: DEPTH 8, DATA_W 16, OP_W 4 and AREG_W 5. With eight slots, both pointers wrap within the first dozen allocations, and the ring fills after eight back-to-back requests. Wrap, the full refusal and the oldest-first pick across the wrap point are therefore all reached in a short run. A 16-bit data path leaves room for operand values that are clearly distinct from the 3-bit tags they replace.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // successor of a ring position
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos + 1 >= depth) ? 0 : pos + 1;
  endfunction

  // position reached by stepping ofs places from base around the ring
  function automatic int unsigned ring_add(input int unsigned base, input int unsigned ofs,
                                           input int unsigned depth);
    int unsigned s;
    s = base + ofs;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             cmt_fire,
  output logic [TAG_W-1:0] head_q,
  output logic [TAG_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q,
  output logic             full
);
  import rob_pkg::*;

  assign full = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= TAG_W'(ring_next(32'(tail_q), DEPTH));
      if (cmt_fire)   head_q <= TAG_W'(ring_next(32'(head_q), DEPTH));
      case ({alloc_fire, cmt_fire})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 3
) (
  input  logic [DEPTH-1:0] ready_vec,
  input  logic [TAG_W-1:0] head,
  output logic             any,
  output logic [TAG_W-1:0] pick,
  output logic [DEPTH-1:0] grant
);
  import rob_pkg::*;

  always_comb begin
    any   = 1'b0;
    pick  = '0;
    grant = '0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      int unsigned idx;
      idx = ring_add(32'(head), unsigned'(k), DEPTH);
      if (!any && ready_vec[idx[TAG_W-1:0]]) begin
        any  = 1'b1;
        pick = idx[TAG_W-1:0];
      end
    end
    grant[pick] = any;
  end
endmodule

// File: rtl/rob_dataflow.sv
module rob_dataflow #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned AREG_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [OP_W-1:0]           alloc_op,
  input  logic [AREG_W-1:0]         alloc_dst,
  input  logic                      alloc_s1_rdy,
  input  logic [DATA_W-1:0]         alloc_s1,
  input  logic                      alloc_s2_rdy,
  input  logic [DATA_W-1:0]         alloc_s2,
  output logic                      alloc_stall,
  output logic [$clog2(DEPTH)-1:0]  alloc_tag,
  input  logic                      res_valid,
  input  logic [$clog2(DEPTH)-1:0]  res_tag,
  input  logic [DATA_W-1:0]         res_data,
  output logic                      iss_valid,
  output logic [$clog2(DEPTH)-1:0]  iss_tag,
  output logic [OP_W-1:0]           iss_op,
  output logic [DATA_W-1:0]         iss_a,
  output logic [DATA_W-1:0]         iss_b,
  output logic                      cmt_valid,
  output logic [AREG_W-1:0]         cmt_dst,
  output logic [DATA_W-1:0]         cmt_data
);
  localparam int unsigned TAG_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // a pending source field is woken by a matching bus beat
  function automatic logic wakes(input logic rdy, input logic [DATA_W-1:0] field,
                                 input logic bus_v, input logic [TAG_W-1:0] bus_t);
    return !rdy && bus_v && (field[TAG_W-1:0] == bus_t);
  endfunction

  // per-slot state
  logic              use_q  [DEPTH];
  logic              exec_q [DEPTH];
  logic              done_q [DEPTH];
  logic [OP_W-1:0]   op_q   [DEPTH];
  logic [AREG_W-1:0] dst_q  [DEPTH];
  logic              r1_q   [DEPTH];
  logic              r2_q   [DEPTH];
  logic [DATA_W-1:0] s1_q   [DEPTH];
  logic [DATA_W-1:0] s2_q   [DEPTH];
  logic [DATA_W-1:0] res_q  [DEPTH];

  // named internal events
  logic             alloc_fire, cmt_fire, full;
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] use_vec, exec_vec, srcs_rdy_vec, ready_vec, grant_vec;
  logic             pick_any;
  logic [TAG_W-1:0] pick_idx;

  assign alloc_fire = alloc_valid && !full;
  assign cmt_fire   = use_q[head_q] && done_q[head_q];

  rob_ring_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .cmt_fire(cmt_fire),
    .head_q(head_q), .tail_q(tail_q), .count_q(count_q), .full(full)
  );

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      use_vec[i]      = use_q[i];
      exec_vec[i]     = exec_q[i];
      srcs_rdy_vec[i] = r1_q[i] && r2_q[i];
      ready_vec[i]    = use_q[i] && !exec_q[i] && r1_q[i] && r2_q[i];
    end
  end

  rob_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
    .ready_vec(ready_vec), .head(head_q), .any(pick_any), .pick(pick_idx), .grant(grant_vec)
  );

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    localparam logic [TAG_W-1:0] MY = TAG_W'(g);
    logic take, fill, drop;
    assign take = alloc_fire && (tail_q == MY);
    assign fill = res_valid && (res_tag == MY) && use_q[g];
    assign drop = cmt_fire && (head_q == MY);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        use_q[g]  <= 1'b0;
        exec_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
        op_q[g]   <= '0;
        dst_q[g]  <= '0;
        r1_q[g]   <= 1'b0;
        r2_q[g]   <= 1'b0;
        s1_q[g]   <= '0;
        s2_q[g]   <= '0;
        res_q[g]  <= '0;
      end else if (take) begin
        use_q[g]  <= 1'b1;
        exec_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
        op_q[g]   <= alloc_op;
        dst_q[g]  <= alloc_dst;
        if (wakes(alloc_s1_rdy, alloc_s1, res_valid, res_tag)) begin
          r1_q[g] <= 1'b1;
          s1_q[g] <= res_data;
        end else begin
          r1_q[g] <= alloc_s1_rdy;
          s1_q[g] <= alloc_s1;
        end
        if (wakes(alloc_s2_rdy, alloc_s2, res_valid, res_tag)) begin
          r2_q[g] <= 1'b1;
          s2_q[g] <= res_data;
        end else begin
          r2_q[g] <= alloc_s2_rdy;
          s2_q[g] <= alloc_s2;
        end
      end else begin
        if (drop)         use_q[g]  <= 1'b0;
        if (grant_vec[g]) exec_q[g] <= 1'b1;
        if (fill) begin
          done_q[g] <= 1'b1;
          res_q[g]  <= res_data;
        end
        if (use_q[g] && wakes(r1_q[g], s1_q[g], res_valid, res_tag)) begin
          r1_q[g] <= 1'b1;
          s1_q[g] <= res_data;
        end
        if (use_q[g] && wakes(r2_q[g], s2_q[g], res_valid, res_tag)) begin
          r2_q[g] <= 1'b1;
          s2_q[g] <= res_data;
        end
      end
    end
  end

  assign alloc_stall = full;
  assign alloc_tag   = tail_q;
  assign iss_valid   = pick_any;
  assign iss_tag     = pick_idx;
  assign iss_op      = op_q[pick_idx];
  assign iss_a       = s1_q[pick_idx];
  assign iss_b       = s2_q[pick_idx];
  assign cmt_valid   = cmt_fire;
  assign cmt_dst     = dst_q[head_q];
  assign cmt_data    = res_q[head_q];
endmodule

// File: rtl/rob_dataflow_chk.sv
module rob_dataflow_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_stall,
  input logic             iss_valid,
  input logic [TAG_W-1:0] iss_tag,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] head_q,
  input logic [TAG_W-1:0] tail_q,
  input logic [CNT_W-1:0] count_q,
  input logic [DEPTH-1:0] use_vec,
  input logic [DEPTH-1:0] exec_vec,
  input logic [DEPTH-1:0] srcs_rdy_vec,
  input logic [DEPTH-1:0] grant_vec
);
  import rob_pkg::*;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) <= DEPTH);

  a_r4_stall_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_stall) |=> (tail_q == $past(tail_q)));

  a_r3_issue_needs_sources: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> srcs_rdy_vec[iss_tag]);

  a_r3_issue_marks_exec: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> exec_vec[$past(iss_tag)]);

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r8_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> (32'(head_q) == ring_next(32'($past(head_q)), DEPTH)));

  a_r8_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> !use_vec[$past(head_q)]);
endmodule

bind rob_dataflow rob_dataflow_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_stall(alloc_stall),
  .iss_valid(iss_valid), .iss_tag(iss_tag), .cmt_valid(cmt_valid),
  .head_q(head_q), .tail_q(tail_q), .count_q(count_q), .use_vec(use_vec),
  .exec_vec(exec_vec), .srcs_rdy_vec(srcs_rdy_vec), .grant_vec(grant_vec)
);

// File: tb/rob_dataflow_bench.sv
module rob_dataflow_bench;
  localparam int DEPTH = 8;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int AW = 5;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic av, r1, r2, rv;
  logic [OW-1:0] op;
  logic [AW-1:0] dst;
  logic [DW-1:0] v1, v2, rd;
  logic [TW-1:0] rt;
  logic stall, iv, cv;
  logic [TW-1:0] atag, itag;
  logic [OW-1:0] iop;
  logic [DW-1:0] ia, ib, cdata;
  logic [AW-1:0] cdst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_dataflow u_rob_dataflow (
    .clk(clk), .rst_n(rst_n), .alloc_valid(av), .alloc_op(op), .alloc_dst(dst),
    .alloc_s1_rdy(r1), .alloc_s1(v1), .alloc_s2_rdy(r2), .alloc_s2(v2),
    .alloc_stall(stall), .alloc_tag(atag), .res_valid(rv), .res_tag(rt), .res_data(rd),
    .iss_valid(iv), .iss_tag(itag), .iss_op(iop), .iss_a(ia), .iss_b(ib),
    .cmt_valid(cv), .cmt_dst(cdst), .cmt_data(cdata)
  );

  typedef struct packed {
    logic av; logic [3:0] op; logic [4:0] dst;
    logic r1; logic [15:0] v1; logic r2; logic [15:0] v2;
    logic rv; logic [2:0] rt; logic [15:0] rd;
    logic e_iss; logic [2:0] e_itag; logic [15:0] e_a; logic [15:0] e_b;
    logic e_cmt; logic [4:0] e_cdst; logic [15:0] e_cdata; logic [2:0] e_atag;
  } vec_t;

  // per cycle: inputs driven, then outputs expected before the next rising edge
  localparam vec_t TBL [7] = '{
    '{1'b1, 4'd1, 5'd3, 1'b1, 16'd10, 1'b1, 16'd20, 1'b0, 3'd0, 16'd0,
      1'b0, 3'd0, 16'd0, 16'd0, 1'b0, 5'd0, 16'd0, 3'd0},
    '{1'b1, 4'd2, 5'd4, 1'b0, 16'd0, 1'b1, 16'd5, 1'b0, 3'd0, 16'd0,
      1'b1, 3'd0, 16'd10, 16'd20, 1'b0, 5'd0, 16'd0, 3'd1},
    '{1'b0, 4'd0, 5'd0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 3'd0, 16'd30,
      1'b0, 3'd0, 16'd0, 16'd0, 1'b0, 5'd0, 16'd0, 3'd2},
    '{1'b0, 4'd0, 5'd0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 3'd0, 16'd0,
      1'b1, 3'd1, 16'd30, 16'd5, 1'b1, 5'd3, 16'd30, 3'd2},
    '{1'b0, 4'd0, 5'd0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 3'd1, 16'd35,
      1'b0, 3'd0, 16'd0, 16'd0, 1'b0, 5'd0, 16'd0, 3'd2},
    '{1'b0, 4'd0, 5'd0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 3'd0, 16'd0,
      1'b0, 3'd0, 16'd0, 16'd0, 1'b1, 5'd4, 16'd35, 3'd2},
    '{1'b0, 4'd0, 5'd0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 3'd0, 16'd0,
      1'b0, 3'd0, 16'd0, 16'd0, 1'b0, 5'd0, 16'd0, 3'd2}
  };

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // drive one cycle's inputs at the falling edge, then let them settle
  task automatic drive(input logic a, input int o, input int d, input logic s1r, input int s1,
                       input logic s2r, input int s2, input logic b, input int bt, input int bd);
    @(negedge clk);
    av = a; op = OW'(o); dst = AW'(d); r1 = s1r; v1 = DW'(s1); r2 = s2r; v2 = DW'(s2);
    rv = b; rt = TW'(bt); rd = DW'(bd);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0);
  endtask

  task automatic exp_iss(input string req, input logic e, input int t, input int a, input int b);
    check(req, "iss_valid", int'(iv), int'(e));
    if (e) begin
      check(req, "iss_tag", int'(itag), t);
      check(req, "iss_a", int'(ia), a);
      check(req, "iss_b", int'(ib), b);
    end
  endtask

  task automatic exp_cmt(input string req, input logic e, input int d, input int v);
    check(req, "cmt_valid", int'(cv), int'(e));
    if (e) begin
      check(req, "cmt_dst", int'(cdst), d);
      check(req, "cmt_data", int'(cdata), v);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    av = 0; op = 0; dst = 0; r1 = 0; v1 = 0; r2 = 0; v2 = 0; rv = 0; rt = 0; rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    check("R1", "alloc_stall", int'(stall), 0);
    check("R1", "alloc_tag", int'(atag), 0);
    check("R1", "iss_valid", int'(iv), 0);
    check("R1", "cmt_valid", int'(cv), 0);

    // table: R2 allocation order, R3 issue, R6 wakeup, R8 commit
    for (int i = 0; i < 7; i++) begin
      vec_t t;
      t = TBL[i];
      drive(t.av, int'(t.op), int'(t.dst), t.r1, int'(t.v1), t.r2, int'(t.v2),
            t.rv, int'(t.rt), int'(t.rd));
      check("R2", "alloc_tag", int'(atag), int'(t.e_atag));
      exp_iss("R3/R6", t.e_iss, int'(t.e_itag), int'(t.e_a), int'(t.e_b));
      exp_cmt("R8", t.e_cmt, int'(t.e_cdst), int'(t.e_cdata));
    end

    // R7 capture at allocation
    drive(1'b1, 3, 5, 1'b1, 1, 1'b1, 2, 1'b0, 0, 0);
    check("R2", "alloc_tag", int'(atag), 2);
    idle();                               exp_iss("R3", 1'b1, 2, 1, 2);
    drive(1'b1, 4, 6, 1'b0, 2, 1'b1, 7, 1'b1, 2, 99);
    exp_iss("R3", 1'b0, 0, 0, 0);
    idle();                               exp_iss("R7", 1'b1, 3, 99, 7);
    exp_cmt("R8", 1'b1, 5, 99);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 3, 11);
    exp_iss("R7", 1'b0, 0, 0, 0);
    idle();                               exp_cmt("R8", 1'b1, 6, 11);

    // R3 out of order, R5 oldest first, R8 in-order retirement
    drive(1'b1, 1, 7, 1'b1, 1, 1'b1, 1, 1'b0, 0, 0);
    drive(1'b1, 2, 8, 1'b0, 4, 1'b1, 2, 1'b0, 0, 0);  exp_iss("R3", 1'b1, 4, 1, 1);
    drive(1'b1, 3, 9, 1'b0, 4, 1'b1, 3, 1'b0, 0, 0);  exp_iss("R3", 1'b0, 0, 0, 0);
    drive(1'b1, 5, 10, 1'b1, 8, 1'b1, 9, 1'b0, 0, 0); exp_iss("R3", 1'b0, 0, 0, 0);
    idle();                                           exp_iss("R3", 1'b1, 7, 8, 9);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 4, 50); exp_iss("R3", 1'b0, 0, 0, 0);
    idle(); exp_iss("R5", 1'b1, 5, 50, 2); exp_cmt("R8", 1'b1, 7, 50);
    idle(); exp_iss("R5", 1'b1, 6, 50, 3); exp_cmt("R8", 1'b0, 0, 0);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 5, 60); exp_cmt("R8", 1'b0, 0, 0);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 6, 61); exp_cmt("R8", 1'b1, 8, 60);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 7, 62); exp_cmt("R8", 1'b1, 9, 61);
    idle(); exp_cmt("R8", 1'b1, 10, 62);
    idle(); exp_cmt("R8", 1'b0, 0, 0);
    check("R9", "alloc_tag after wrap", int'(atag), 0);
    check("R4", "alloc_stall empty", int'(stall), 0);

    // R4 fill the ring, then try one more
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, i, 16 + i, 1'b1, i, 1'b1, i + 1, 1'b0, 0, 0);
      check("R2", "alloc_tag fill", int'(atag), i);
      check("R4", "alloc_stall fill", int'(stall), 0);
    end
    drive(1'b1, 15, 31, 1'b1, 500, 1'b1, 501, 1'b0, 0, 0);
    check("R4", "alloc_stall full", int'(stall), 1);
    idle();
    check("R4", "alloc_stall held", int'(stall), 1);
    check("R4", "alloc_tag held", int'(atag), 0);
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b1, k, 100 + k);
      exp_iss("R3", 1'b0, 0, 0, 0);
      if (k == 0) exp_cmt("R8", 1'b0, 0, 0);
      else        exp_cmt("R8", 1'b1, 16 + k - 1, 100 + k - 1);
    end
    idle(); exp_cmt("R8", 1'b1, 23, 107);
    idle(); exp_cmt("R4", 1'b0, 0, 0);
    check("R4", "alloc_stall drained", int'(stall), 0);
    exp_iss("R4", 1'b0, 0, 0, 0);

    // R1 reset in mid-run
    drive(1'b1, 1, 1, 1'b1, 3, 1'b1, 4, 1'b0, 0, 0);
    @(negedge clk); av = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1", "iss_valid after reset", int'(iv), 0);
    check("R1", "alloc_tag after reset", int'(atag), 0);
    check("R1", "cmt_valid after reset", int'(cv), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule